// File: doc/BRIEF.md
# Periodic Interrupt Timer Channel Bank

This block holds four independent periodic timers behind one small synchronous register port. Every channel owns a 16-bit down-counter and a 16-bit reload value. The counter steps down once on each cycle where the shared `tick` input is high and the channel is running. A tick that finds the counter at zero copies the reload value back into the counter and raises the channel's time-out flag. With a reload value of N, the flag therefore fires once every N+1 ticks.

Software may write a new reload value at any time. The running count is not disturbed, and the new modulus takes hold at the next wrap. If the new period must start at once, a separate kick strobe copies the stored reload value straight into the counter. Each channel drives an interrupt line that is its flag gated by a per-channel interrupt enable. Flags are cleared by writing ones.

Top module: `pit_bank`

## Requirements
- R1: After a synchronous reset, every reload value, counter, run bit, interrupt-enable bit and flag reads zero, and `irq` is all zero.
- R2: A write to address 4+i stores all 16 bits of `bus_wdata` as channel i's reload value in one cycle. Address 4+i reads it back, and no other write changes it.
- R3: Writing a reload value leaves the running count of that channel unchanged. The new value first enters the counter at the next wrap.
- R4: A counter decrements by one only on a clock edge where `tick` is high and its run bit (bit i of address 0) is set. When its run bit is clear, or `tick` is low, it holds its value.
- R5: A tick that finds a running counter at zero loads the reload value into the counter and sets the channel's flag. With reload N, the flag sets once every N+1 ticks, and N=0 wraps on every tick.
- R6: Writing a 1 to bit i of address 1 (kick) copies channel i's reload value into its counter on that clock edge, whatever `tick` is. It does not change the flag. Zeros in the kick word have no effect.
- R7: On the first edge after a channel's run bit goes from 0 to 1, its counter is loaded from the reload value, and any tick on that edge is not counted.
- R8: Address 2 reads the flags in bits 3:0. Writing a 1 to bit i clears flag i, and a 0 leaves it. If a wrap and a clear of the same flag fall on the same edge, the flag stays set.
- R9: `irq[i]` is high exactly when flag i and interrupt-enable bit i (bit 4+i of address 0) are both set.
- R10: Channels are independent. Each counts, wraps and flags according to its own reload value and run bit under one shared tick stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared count enable, one step per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address: 0 control, 1 kick, 2 flags, 4..7 reload, 8..11 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
The assertions assume that at most one register write lands per cycle, so a kick, a flag clear and a reload update never arrive together in the same cycle. They also assume that `tick` is a plain level that is sampled once per clock edge. The stimulus issues exactly one bus operation per cycle and uses only mapped addresses. It overlaps a tick with a control-plane write only in the deliberate case of a flag clear that meets a wrap. A cycle-level arithmetic model in the bench follows every edge, including run-bit starts and kicks, and predicts every counter, flag and interrupt line.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam int IW  = $clog2(NCH);

    // address pages: upper two address bits
    localparam logic [1:0] PG_SYS    = 2'b00;
    localparam logic [1:0] PG_RELOAD = 2'b01;
    localparam logic [1:0] PG_COUNT  = 2'b10;

    typedef enum logic [1:0] {
        SYS_CTRL = 2'd0,
        SYS_KICK = 2'd1,
        SYS_STAT = 2'd2,
        SYS_RSVD = 2'd3
    } sys_reg_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_DEC,
        ACT_WRAP
    } act_e;

    typedef struct packed {
        logic run;
        logic irq_en;
        logic kick;
        logic ack;
    } chan_ctl_t;

    // per-edge counter action, in priority order
    function automatic act_e pick_action(
        input logic run,
        input logic run_d,
        input logic kick,
        input logic tick,
        input logic zero
    );
        if ((run && !run_d) || kick) begin
            return ACT_LOAD;
        end
        if (run && tick) begin
            return zero ? ACT_WRAP : ACT_DEC;
        end
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int N  = NCH,
    parameter int W  = CW,
    parameter int A  = AW,
    parameter int XW = IW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [A-1:0]            addr,
    input  logic [W-1:0]            wdata,
    input  logic [N-1:0][W-1:0]     cnt_i,
    input  logic [N-1:0]            flag_i,
    output chan_ctl_t [N-1:0]       ctl_o,
    output logic [N-1:0][W-1:0]     reload_o,
    output logic [W-1:0]            rdata
);

    logic [N-1:0]        run_q;
    logic [N-1:0]        ien_q;
    logic [N-1:0][W-1:0] reload_q;

    logic [1:0]    page;
    logic [1:0]    sreg;
    logic [XW-1:0] idx;

    assign page = addr[A-1:A-2];
    assign sreg = addr[1:0];
    assign idx  = addr[XW-1:0];

    logic wr_ctrl, wr_kick, wr_stat, wr_reload;
    assign wr_ctrl   = we && (page == PG_SYS) && (sreg == SYS_CTRL);
    assign wr_kick   = we && (page == PG_SYS) && (sreg == SYS_KICK);
    assign wr_stat   = we && (page == PG_SYS) && (sreg == SYS_STAT);
    assign wr_reload = we && (page == PG_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            ien_q    <= '0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q <= wdata[N-1:0];
                ien_q <= wdata[2*N-1:N];
            end
            if (wr_reload) begin
                reload_q[idx] <= wdata;
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_ctl
        assign ctl_o[i].run    = run_q[i];
        assign ctl_o[i].irq_en = ien_q[i];
        assign ctl_o[i].kick   = wr_kick && wdata[i];
        assign ctl_o[i].ack    = wr_stat && wdata[i];
    end

    assign reload_o = reload_q;

    always_comb begin
        rdata = '0;
        unique case (page)
            PG_SYS: begin
                unique case (sreg)
                    SYS_CTRL: begin
                        rdata[N-1:0]   = run_q;
                        rdata[2*N-1:N] = ien_q;
                    end
                    SYS_STAT: rdata[N-1:0] = flag_i;
                    default:  rdata = '0;
                endcase
            end
            PG_RELOAD: rdata = reload_q[idx];
            PG_COUNT:  rdata = cnt_i[idx];
            default:   rdata = '0;
        endcase
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_RELOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
            (wr_reload && idx == XW'(i)) |=> reload_q[i] == $past(wdata)); // R2
        AST_RELOAD_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            !(wr_reload && idx == XW'(i)) |=> $stable(reload_q[i])); // R2
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  chan_ctl_t    ctl_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         flag_o,
    output logic         irq_o
);

    logic [W-1:0] cnt_q;
    logic         run_d;
    logic         flag_q;
    act_e         act;

    assign act = pick_action(ctl_i.run, run_d, ctl_i.kick, tick_i, cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            run_d  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            run_d <= ctl_i.run;
            unique case (act)
                ACT_LOAD: cnt_q <= reload_i;
                ACT_WRAP: cnt_q <= reload_i;
                ACT_DEC:  cnt_q <= cnt_q - W'(1);
                default:  cnt_q <= cnt_q;
            endcase
            flag_q <= (act == ACT_WRAP) || (flag_q && !ctl_i.ack);
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q && ctl_i.irq_en;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.run && !ctl_i.kick) |=> $stable(cnt_q)); // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && run_d && !ctl_i.kick && !tick_i) |=> $stable(cnt_q)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && run_d && !ctl_i.kick && tick_i && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - W'(1)); // R4
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && run_d && !ctl_i.kick && tick_i && cnt_q == '0)
        |=> (flag_q && cnt_q == $past(reload_i))); // R5
    AST_KICK_LOADS: assert property (@(posedge clk) disable iff (rst)
        ctl_i.kick |=> cnt_q == $past(reload_i)); // R6
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && !run_d) |=> cnt_q == $past(reload_i)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.ack && !(ctl_i.run && run_d && !ctl_i.kick && tick_i && cnt_q == '0))
        |=> !flag_q); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.ack && ctl_i.run && run_d && !ctl_i.kick && tick_i && cnt_q == '0)
        |=> flag_q); // R8

endmodule

// File: rtl/pit_bank.sv
module pit_bank
    import pit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NCH-1:0] irq
);

    chan_ctl_t [NCH-1:0]       ctl;
    logic [NCH-1:0][CW-1:0]    reload;
    logic [NCH-1:0][CW-1:0]    cnt;
    logic [NCH-1:0]            flag;

    pit_regs #(.N(NCH), .W(CW), .A(AW), .XW(IW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt_i    (cnt),
        .flag_i   (flag),
        .ctl_o    (ctl),
        .reload_o (reload),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pit_channel #(.W(CW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (tick),
            .ctl_i    (ctl[i]),
            .reload_i (reload[i]),
            .cnt_o    (cnt[i]),
            .flag_o   (flag[i]),
            .irq_o    (irq[i])
        );
    end

endmodule

// File: tb/tb_pit_bank.sv
`timescale 1ns/100ps
module tb_pit_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the bank
    logic [15:0] mrel [4];
    logic [15:0] mcnt [4];
    bit men [4], mend [4], mie [4], mflag [4];

    pit_bank dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic model_edge(input bit tk, input bit we, input logic [3:0] a, input logic [15:0] d);
        for (int i = 0; i < 4; i++) begin
            bit wrap = 0;
            if ((men[i] && !mend[i]) || (we && a == 4'd1 && d[i])) begin
                mcnt[i] = mrel[i];
            end else if (men[i] && tk) begin
                if (mcnt[i] == 16'd0) begin
                    mcnt[i] = mrel[i];
                    wrap = 1;
                end else begin
                    mcnt[i] = mcnt[i] - 16'd1;
                end
            end
            mflag[i] = wrap || (mflag[i] && !(we && a == 4'd2 && d[i]));
            mend[i] = men[i];
        end
        if (we && a == 4'd0) begin
            for (int i = 0; i < 4; i++) begin
                men[i] = d[i];
                mie[i] = d[4+i];
            end
        end
        if (we && a[3:2] == 2'b01) mrel[a[1:0]] = d;
    endtask

    task automatic cyc(input bit tk, input bit we, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        tick = tk; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge(tk, we, a, d);
        #1;
        tick = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [15:0] v;
        logic [15:0] ef, ei, ec;
        ef = '0; ei = '0; ec = '0;
        for (int i = 0; i < 4; i++) begin
            rd(4'(8 + i), v);
            chk(tag, $sformatf("count ch%0d", i), v, mcnt[i]);
            rd(4'(4 + i), v);
            chk(tag, $sformatf("reload ch%0d", i), v, mrel[i]);
            ef[i] = mflag[i];
            ei[i] = mflag[i] && mie[i];
            ec[i] = men[i];
            ec[4+i] = mie[i];
        end
        rd(4'd2, v);
        chk(tag, "flags", v, ef);
        rd(4'd0, v);
        chk(tag, "control", v, ec);
        chk(tag, "irq", {12'd0, irq}, ei);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            mrel[i] = 0; mcnt[i] = 0; men[i] = 0; mend[i] = 0; mie[i] = 0; mflag[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");

        // R2: full-word reload writes and readback
        cyc(0, 1, 4'd4, 16'hFFFF);
        rd(4'd4, v); chk("R2", "reload full word", v, 16'hFFFF);
        cyc(0, 1, 4'd4, 16'd3);
        cyc(0, 1, 4'd5, 16'd5);
        cyc(0, 1, 4'd6, 16'd0);
        cyc(0, 1, 4'd7, 16'd7);
        check_all("R2");

        // R7: start loads from reload
        cyc(0, 1, 4'd0, 16'h00FF);
        cyc(0, 0, 4'd0, 16'd0);
        check_all("R7");

        // R5: periods N+1, including N=0
        for (int k = 0; k < 20; k++) begin
            cyc(1, 0, 4'd0, 16'd0);
            check_all("R5");
        end

        // R9: interrupt gating
        cyc(0, 1, 4'd0, 16'h005F);
        check_all("R9");

        // R3: reload write mid-count leaves count running
        cyc(0, 1, 4'd7, 16'h0100);
        check_all("R3");
        for (int k = 0; k < 10; k++) begin
            cyc(1, 0, 4'd0, 16'd0);
            check_all("R3");
        end

        // R8: clear by writing ones, zeros ignored, set wins
        cyc(0, 1, 4'd2, 16'h0000);
        check_all("R8");
        cyc(0, 1, 4'd2, 16'h0001);
        check_all("R8");
        cyc(1, 1, 4'd2, 16'h0004);
        rd(4'd2, v); chk("R8", "set wins over clear", {15'd0, v[2]}, 16'd1);
        check_all("R8");

        // R6: kick loads immediately, flag untouched
        cyc(0, 1, 4'd5, 16'd9);
        cyc(0, 1, 4'd1, 16'h0002);
        rd(4'd9, v); chk("R6", "kick count", v, 16'd9);
        check_all("R6");

        // R4: disabled channel holds, tick low holds
        cyc(0, 1, 4'd0, 16'h005E);
        for (int k = 0; k < 5; k++) begin
            cyc(1, 0, 4'd0, 16'd0);
            check_all("R4");
        end
        for (int k = 0; k < 3; k++) begin
            cyc(0, 0, 4'd0, 16'd0);
            check_all("R4");
        end
        cyc(0, 1, 4'd0, 16'h005F);
        cyc(1, 0, 4'd0, 16'd0);
        check_all("R7");

        // R5 sweep over small reload values on channel 0
        for (int n = 0; n < 10; n++) begin
            cyc(0, 1, 4'd4, 16'(n));
            cyc(0, 1, 4'd1, 16'h0001);
            for (int k = 0; k < 2 * n + 3; k++) begin
                cyc(1, 0, 4'd0, 16'd0);
                check_all("R5");
            end
        end

        // R10: mixed periods under an irregular tick stream
        cyc(0, 1, 4'd4, 16'd2);
        cyc(0, 1, 4'd5, 16'd3);
        cyc(0, 1, 4'd6, 16'd5);
        cyc(0, 1, 4'd7, 16'd11);
        cyc(0, 1, 4'd1, 16'h000F);
        cyc(0, 1, 4'd2, 16'h000F);
        for (int k = 0; k < 120; k++) begin
            cyc((k % 3) != 2, (k % 17) == 16, 4'd2, 16'h0003);
            check_all("R10");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule